// File: doc/BRIEF.md
# Two-Wide Register Renamer

This block renames a group of up to two instructions in one cycle. Each slot carries two architectural source registers and an optional architectural destination. The block looks up four source mappings and two old destination mappings in a mapping table. It takes up to two physical tags from an internal free pool, and commits the new destination mappings when the group is accepted. The second slot's sources and old destination are forwarded from the first slot's new tag whenever the first slot writes that architectural register, so the pair behaves as if renamed one after the other.

The group enters on a valid/ready stream and leaves on a valid/ready stream. The results are combinational from the accepted group. A group transfers on a clock edge where `in_valid`, `in_ready` and `out_ready` are all high. `out_valid` depends only on `in_valid` and the free pool level, never on `out_ready`. `in_ready` is `out_ready` qualified by the free pool level, so back-pressure passes straight through. Physical tags come back to the pool one at a time through a plain release pin pair.

Top module: `reg_renamer2`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free pool holds tags ARCH_REGS through PHYS_REGS-1 in ascending order, so the first two allocations are 32 and 33 with default parameters.
- R2: Each valid slot reports the current mapping of both its sources in the same cycle it is presented. An invalid slot reports tag 0 for every output field.
- R3: A slot is renamed when it is valid, its destination flag is set and its destination is not register 0. Each renamed slot gets the next free tag, slot 0 before slot 1. Its old tag is the mapping being replaced. The two new tags differ, and neither is 0.
- R4: If slot 1 reads a register that a renamed slot 0 writes in the same group, slot 1 receives slot 0's new tag for that source.
- R5: If both slots are renamed to the same destination, slot 1's new tag is left in the table, and slot 1's reported old tag is slot 0's new tag.
- R6: A slot with no destination, or with destination register 0, takes no tag and changes no mapping. It reports new and old tags of 0 and a clear `out_renamed` bit. Register 0 always maps to tag 0.
- R7: A slot whose valid bit is clear has no effect on the table or the pool, whatever its other fields hold.
- R8: While fewer than two tags are free, `in_ready` and `out_valid` are low. Nothing is taken from the pool and no mapping changes.
- R9: With `out_ready` low, `in_ready` is low and no state changes, while `out_valid` still follows `in_valid`.
- R10: A tag released through `rel_valid`/`rel_tag` joins the tail of the pool and is handed out after every tag already waiting.
- R11: Mappings written by an accepted group are seen by the group presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group on the input is valid |
| in_ready | output | 1 | Group is accepted this cycle |
| in_slot_vld | input | 2 | Per-slot valid bit |
| in_src_a | input | 2*AW | First source register, slot k at bits [k*AW +: AW] |
| in_src_b | input | 2*AW | Second source register, same layout |
| in_dst | input | 2*AW | Destination register, same layout |
| in_has_dst | input | 2 | Slot writes a destination |
| out_valid | output | 1 | Renamed group is valid |
| out_ready | input | 1 | Downstream accepts the group |
| out_psrc_a | output | 2*PW | Physical tag of first source, slot k at [k*PW +: PW] |
| out_psrc_b | output | 2*PW | Physical tag of second source |
| out_pdst | output | 2*PW | Newly allocated destination tag |
| out_pold | output | 2*PW | Tag previously mapped to the destination |
| out_renamed | output | 2 | Slot received a new tag |
| rel_valid | input | 1 | Return a tag to the free pool |
| rel_tag | input | PW | Tag being returned |

## Verification
The source, new and old tags and both handshake signals are combinational, so they are due in the same cycle the group is driven. The bench drives on the falling edge and samples them 5 ns later, before the next rising edge. Table and pool updates take effect on the rising edge that accepts the group or the release. Each one is checked by presenting a fresh group on the following falling edge and reading the tags it reports. Stalled or back-pressured groups are re-presented after the blocking cycle, and the tags they receive must match an unchanged model.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_WIDTH       = 2;
  localparam int RN_SRC_PORTS   = 2 * RN_WIDTH;
  localparam int RN_TBL_PORTS   = RN_SRC_PORTS + RN_WIDTH;

  // Number of tags a group asks the pool for.
  function automatic logic [1:0] rn_demand(input logic [1:0] need);
    return {1'b0, need[0]} + {1'b0, need[1]};
  endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int PHYS_REGS  = 64,
  parameter int FIRST_FREE = 32,
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pop_n,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  output logic [PW-1:0] head0,
  output logic [PW-1:0] head1,
  output logic [CW-1:0] cnt
);
  localparam int INIT_CNT = PHYS_REGS - FIRST_FREE;

  logic [PW-1:0] pool [PHYS_REGS];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= PHYS_REGS) s = s - PHYS_REGS;
    return PW'(s);
  endfunction

  assign head0 = pool[rd_ptr];
  assign head1 = pool[adv(rd_ptr, 1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < PHYS_REGS; j++)
        pool[j] <= (j < INIT_CNT) ? PW'(FIRST_FREE + j) : '0;
      rd_ptr <= '0;
      wr_ptr <= adv('0, INIT_CNT);
      cnt    <= CW'(INIT_CNT);
    end else begin
      if (push) begin
        pool[wr_ptr] <= push_tag;
        wr_ptr       <= adv(wr_ptr, 1);
      end
      rd_ptr <= adv(rd_ptr, int'(pop_n));
      cnt    <= cnt + CW'(push) - CW'(pop_n);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= cnt); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(cnt) - int'(pop_n)) < PHYS_REGS); // R10
  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n == 2'd1) |=> head0 == $past(head1)); // R3
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 32,
  parameter int PW        = 6,
  parameter int NRD       = 6,
  localparam int AW = $clog2(ARCH_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [PW-1:0] rd_data [NRD],
  input  logic [1:0]    we,
  input  logic [AW-1:0] wa [2],
  input  logic [PW-1:0] wd [2]
);
  logic [PW-1:0] map [ARCH_REGS];

  genvar g;
  generate
    for (g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g] = map[rd_addr[g]];
    end
  endgenerate

  // Entry 0 is pinned; port 1 wins when both ports target one entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map[i] <= PW'(i);
    end else begin
      for (int i = 1; i < ARCH_REGS; i++) begin
        if (we[1] && wa[1] == AW'(i))      map[i] <= wd[1];
        else if (we[0] && wa[0] == AW'(i)) map[i] <= wd[0];
      end
    end
  end

  AST_PORT1_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we[1] && wa[1] != '0) |=> map[$past(wa[1])] == $past(wd[1])); // R5
  AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[0] == '0) |-> rd_data[0] == '0); // R6
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
  parameter int AW = 5,
  parameter int PW = 6
) (
  input  logic [1:0]    slot_vld,
  input  logic [1:0]    has_dst,
  input  logic [AW-1:0] dst [2],
  input  logic [AW-1:0] srca [2],
  input  logic [AW-1:0] srcb [2],
  input  logic [PW-1:0] tbl_srca [2],
  input  logic [PW-1:0] tbl_srcb [2],
  input  logic [PW-1:0] tbl_old [2],
  input  logic [PW-1:0] head0,
  input  logic [PW-1:0] head1,
  output logic [1:0]    need,
  output logic [PW-1:0] psrca [2],
  output logic [PW-1:0] psrcb [2],
  output logic [PW-1:0] pdst [2],
  output logic [PW-1:0] pold [2],
  output logic [1:0]    pop_n
);
  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_need
      assign need[k] = slot_vld[k] && has_dst[k] && (dst[k] != '0);
    end
  endgenerate

  assign pop_n = rn_pkg::rn_demand(need);

  logic hit_a, hit_b, hit_d;
  assign hit_a = need[0] && (dst[0] == srca[1]);
  assign hit_b = need[0] && (dst[0] == srcb[1]);
  assign hit_d = need[0] && (dst[0] == dst[1]);

  always_comb begin
    pdst[0]  = need[0] ? head0 : '0;
    pold[0]  = need[0] ? tbl_old[0] : '0;
    psrca[0] = slot_vld[0] ? tbl_srca[0] : '0;
    psrcb[0] = slot_vld[0] ? tbl_srcb[0] : '0;

    pdst[1]  = '0;
    pold[1]  = '0;
    if (need[1]) begin
      pdst[1] = need[0] ? head1 : head0;
      pold[1] = hit_d ? pdst[0] : tbl_old[1];
    end
    psrca[1] = '0;
    psrcb[1] = '0;
    if (slot_vld[1]) begin
      psrca[1] = hit_a ? pdst[0] : tbl_srca[1];
      psrcb[1] = hit_b ? pdst[0] : tbl_srcb[1];
    end
  end
endmodule

// File: rtl/reg_renamer2.sv
module reg_renamer2 #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_slot_vld,
  input  logic [2*AW-1:0] in_src_a,
  input  logic [2*AW-1:0] in_src_b,
  input  logic [2*AW-1:0] in_dst,
  input  logic [1:0]    in_has_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2*PW-1:0] out_psrc_a,
  output logic [2*PW-1:0] out_psrc_b,
  output logic [2*PW-1:0] out_pdst,
  output logic [2*PW-1:0] out_pold,
  output logic [1:0]    out_renamed,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag
);
  localparam int CW   = $clog2(PHYS_REGS + 1);
  localparam int NRD  = rn_pkg::RN_TBL_PORTS;

  logic [AW-1:0] srca [2], srcb [2], dst [2];
  logic [AW-1:0] rd_addr [NRD];
  logic [PW-1:0] rd_data [NRD];
  logic [PW-1:0] tbl_srca [2], tbl_srcb [2], tbl_old [2];
  logic [PW-1:0] psrca [2], psrcb [2], pdst [2], pold [2];
  logic [PW-1:0] wd [2];
  logic [PW-1:0] head0, head1;
  logic [CW-1:0] fl_cnt;
  logic [1:0]    need, demand, pop_n, we;
  logic          free_ok, fire;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_slot
      assign srca[k] = in_src_a[k*AW +: AW];
      assign srcb[k] = in_src_b[k*AW +: AW];
      assign dst[k]  = in_dst[k*AW +: AW];
      // Table ports: sources 0..3, old destinations 4..5.
      assign rd_addr[2*k]     = srca[k];
      assign rd_addr[2*k + 1] = srcb[k];
      assign rd_addr[4 + k]   = dst[k];
      assign tbl_srca[k] = rd_data[2*k];
      assign tbl_srcb[k] = rd_data[2*k + 1];
      assign tbl_old[k]  = rd_data[4 + k];
      assign out_psrc_a[k*PW +: PW] = psrca[k];
      assign out_psrc_b[k*PW +: PW] = psrcb[k];
      assign out_pdst[k*PW +: PW]   = pdst[k];
      assign out_pold[k*PW +: PW]   = pold[k];
      assign we[k] = fire && need[k];
      assign wd[k] = pdst[k];
    end
  endgenerate

  assign free_ok     = fl_cnt >= CW'(2);
  assign out_valid   = in_valid && free_ok;
  assign in_ready    = out_ready && free_ok;
  assign fire        = in_valid && in_ready;
  assign pop_n       = fire ? demand : 2'd0;
  assign out_renamed = need;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PW(PW), .NRD(NRD)) u_map (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .we(we), .wa(dst), .wd(wd)
  );

  rn_free_list #(.PHYS_REGS(PHYS_REGS), .FIRST_FREE(ARCH_REGS)) u_pool (
    .clk(clk), .rst_n(rst_n), .pop_n(pop_n), .push(rel_valid),
    .push_tag(rel_tag), .head0(head0), .head1(head1), .cnt(fl_cnt)
  );

  rn_bypass #(.AW(AW), .PW(PW)) u_byp (
    .slot_vld(in_slot_vld), .has_dst(in_has_dst), .dst(dst),
    .srca(srca), .srcb(srcb), .tbl_srca(tbl_srca), .tbl_srcb(tbl_srcb),
    .tbl_old(tbl_old), .head0(head0), .head1(head1), .need(need),
    .psrca(psrca), .psrcb(psrcb), .pdst(pdst), .pold(pold), .pop_n(demand)
  );

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !rel_valid) |=> fl_cnt == $past(fl_cnt)); // R8
  AST_DISTINCT_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need == 2'b11) |-> pdst[0] != pdst[1]); // R3
  AST_NONZERO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need[0]) |-> pdst[0] != '0); // R3
  AST_GROUP_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need[0] && in_slot_vld[1] && srca[1] == dst[0]) |-> psrca[1] == pdst[0]); // R4
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !rel_valid) |=> fl_cnt == $past(fl_cnt)); // R9
endmodule

// File: tb/tb_reg_renamer2.sv
module tb_reg_renamer2;
  localparam int AW = 5;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, rel_valid;
  logic [1:0] in_slot_vld, in_has_dst, out_renamed;
  logic [2*AW-1:0] in_src_a, in_src_b, in_dst;
  logic [2*PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;
  logic [PW-1:0] rel_tag;

  int checks = 0;
  int errors = 0;
  int map [32];
  int fq [$];
  int retired [$];

  always #10 clk = ~clk;

  reg_renamer2 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst(in_dst), .in_has_dst(in_has_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
    .out_pdst(out_pdst), .out_pold(out_pold), .out_renamed(out_renamed),
    .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v0, input int a0, input int b0, input int d0, input bit h0,
                       input bit v1, input int a1, input int b1, input int d1, input bit h1);
    in_valid    = 1'b1;
    in_slot_vld = {v1, v0};
    in_src_a    = {AW'(a1), AW'(a0)};
    in_src_b    = {AW'(b1), AW'(b0)};
    in_dst      = {AW'(d1), AW'(d0)};
    in_has_dst  = {h1, h0};
  endtask

  // Presents one group, checks every output against the model, commits it.
  task automatic run_group(input string tag,
      input bit v0, input int a0, input int b0, input int d0, input bit h0,
      input bit v1, input int a1, input int b1, input int d1, input bit h1);
    bit n0, n1;
    int ea0, eb0, ea1, eb1, ep0, ep1, eo0, eo1;
    n0 = v0 && h0 && d0 != 0;
    n1 = v1 && h1 && d1 != 0;
    ep0 = n0 ? fq[0] : 0;
    ep1 = n1 ? (n0 ? fq[1] : fq[0]) : 0;
    ea0 = v0 ? map[a0] : 0;
    eb0 = v0 ? map[b0] : 0;
    ea1 = v1 ? ((n0 && d0 == a1) ? ep0 : map[a1]) : 0;
    eb1 = v1 ? ((n0 && d0 == b1) ? ep0 : map[b1]) : 0;
    eo0 = n0 ? map[d0] : 0;
    eo1 = n1 ? ((n0 && d0 == d1) ? ep0 : map[d1]) : 0;
    drive(v0, a0, b0, d0, h0, v1, a1, b1, d1, h1);
    #5;
    chk({tag, " in_ready"}, int'(in_ready), 1);
    chk({tag, " out_valid"}, int'(out_valid), 1);
    chk({tag, " renamed"}, int'(out_renamed), int'({n1, n0}));
    chk({tag, " s0 src_a"}, int'(out_psrc_a[0 +: PW]), ea0);
    chk({tag, " s0 src_b"}, int'(out_psrc_b[0 +: PW]), eb0);
    chk({tag, " s1 src_a"}, int'(out_psrc_a[PW +: PW]), ea1);
    chk({tag, " s1 src_b"}, int'(out_psrc_b[PW +: PW]), eb1);
    chk({tag, " s0 pdst"}, int'(out_pdst[0 +: PW]), ep0);
    chk({tag, " s1 pdst"}, int'(out_pdst[PW +: PW]), ep1);
    chk({tag, " s0 pold"}, int'(out_pold[0 +: PW]), eo0);
    chk({tag, " s1 pold"}, int'(out_pold[PW +: PW]), eo1);
    @(posedge clk);
    if (n0) begin void'(fq.pop_front()); map[d0] = ep0; retired.push_back(eo0); end
    if (n1) begin void'(fq.pop_front()); map[d1] = ep1; retired.push_back(eo1); end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic release_tag(input int t);
    rel_valid = 1'b1;
    rel_tag   = PW'(t);
    @(posedge clk);
    fq.push_back(t);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic t_reset_state;
    // R1: identity mapping and first two free tags 32, 33
    run_group("R1 identity", 1, 7, 31, 0, 0, 1, 0, 12, 0, 0);
    chk("R1 first tag", fq[0], 32);
    run_group("R1 first alloc", 1, 1, 2, 3, 1, 1, 5, 6, 4, 1);
  endtask

  task automatic t_basic;
    // R2 R3 R11: next group sees the mappings just written
    run_group("R11 readback", 1, 3, 4, 8, 1, 1, 4, 3, 9, 1);
    run_group("R2 four reads", 1, 8, 9, 0, 0, 1, 3, 4, 0, 0);
  endtask

  task automatic t_bypass;
    // R4: slot 1 reads slot 0's destination on both operands
    run_group("R4 raw both", 1, 2, 2, 11, 1, 1, 11, 11, 12, 1);
    run_group("R4 raw b", 1, 1, 1, 13, 1, 1, 5, 13, 0, 0);
  endtask

  task automatic t_same_dst;
    // R5: both slots write register 14
    run_group("R5 waw", 1, 1, 2, 14, 1, 1, 14, 3, 14, 1);
    run_group("R5 table", 1, 14, 14, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_dst;
    // R6: zero destination and missing destination flag
    run_group("R6 r0 write", 1, 0, 0, 0, 1, 1, 15, 0, 15, 0);
    run_group("R6 unchanged", 1, 0, 15, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_single_slot;
    // R7: invalid slot 0 carries a destination that must be ignored
    run_group("R7 slot0 off", 0, 9, 9, 9, 1, 1, 9, 1, 10, 1);
    run_group("R7 no write", 1, 9, 10, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure;
    // R9: out_ready low blocks acceptance, then same group renames as if fresh
    out_ready = 1'b0;
    drive(1, 1, 2, 20, 1, 1, 3, 4, 21, 1);
    #5;
    chk("R9 in_ready low", int'(in_ready), 0);
    chk("R9 out_valid", int'(out_valid), 1);
    @(negedge clk);
    out_ready = 1'b1;
    run_group("R9 retry", 1, 1, 2, 20, 1, 1, 3, 4, 21, 1);
  endtask

  task automatic t_drain_stall_release;
    int r;
    r = 1;
    while (fq.size() >= 2) begin
      run_group("R3 drain", 1, r, r + 1, r, 1, 1, r + 2, r, r + 1, 1);
      r = (r % 27) + 1;
    end
    // R8: pool below two entries blocks the group
    drive(1, 5, 6, 22, 1, 1, 7, 8, 23, 1);
    #5;
    chk("R8 in_ready", int'(in_ready), 0);
    chk("R8 out_valid", int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    // R10: released tags are handed out after waiting ones, in order
    release_tag(retired[0]);
    release_tag(retired[1]);
    run_group("R10 reuse", 1, 5, 6, 22, 1, 1, 22, 8, 23, 1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog R1 actual %0d expected below %0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) map[i] = i;
    for (int i = 32; i < 64; i++) fq.push_back(i);
    rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b1; rel_valid = 1'b0; rel_tag = '0;
    in_slot_vld = '0; in_has_dst = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_basic();
    t_bypass();
    t_same_dst();
    t_no_dst();
    t_single_slot();
    t_backpressure();
    t_drain_stall_release();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule